// File: doc/BRIEF.md
# 8-bit ALU with status flags

A purely combinational arithmetic and logic unit for a small register-to-register processor. Each cycle it receives two 8-bit operands, a 5-bit operation code and the current 8-bit status vector. It returns an 8-bit result, a write-enable for the destination register and the next status vector. The operand source does not matter to the unit, so the immediate forms of the instructions reuse the register opcodes with the constant placed on `b_i`.

Every operation owns a fixed mask of the status bits it may change. Bits outside that mask pass from `flags_i` to `flags_o` unchanged. The status vector is laid out from bit 7 down to bit 0 as: interrupt enable, transfer bit, half carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C). Bits 7 and 6 are never written here.

The operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 AND, 7 OR, 8 XOR, 9 one's complement, 10 negate, 11 increment, 12 decrement, 13 shift left, 14 shift right, 15 rotate left through carry, 16 rotate right through carry, 17 arithmetic shift right and 18 nibble swap. Codes 19 to 31 are unassigned.

Top module: `alu8_core`

## Requirements
- R1: Status bits 7 and 6 of `flags_o` always equal those of `flags_i`. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5.
- R2: Code 0 gives a+b and code 1 gives a+b+C, with `wr_en_o`=1. C is the carry out of bit 7, H the carry out of bit 3, V the signed overflow, N bit 7 of the result and Z set when the result is zero.
- R3: Code 2 gives a-b and code 3 gives a-b-C, with `wr_en_o`=1. C is set when the unsigned difference goes below zero, H is the borrow into bit 4, V the signed overflow, and N and Z follow the result.
- R4: For codes 3 and 5 the new Z is 1 only when the result is zero and the incoming Z is 1, so Z can be cleared but never set.
- R5: Codes 4 and 5 produce the same `res_o` and flags as codes 2 and 3, but `wr_en_o`=0.
- R6: Codes 6, 7 and 8 give a AND b, a OR b and a XOR b. They set Z and N from the result, clear V, and keep C and H.
- R7: Code 9 gives 0xFF-a with C=1 and V=0, and keeps H.
- R8: Code 10 gives 0x00-a and updates C, Z, N, V and H as the subtraction 0-a would.
- R9: Code 11 gives a+1 with V set only for a=0x7F. Code 12 gives a-1 with V set only for a=0x80. Both keep C and H.
- R10: Code 13 shifts left with 0 into bit 0. Code 14 shifts right with 0 into bit 7. Code 15 rotates left and code 16 rotates right, each through C. Code 17 shifts right and keeps bit 7. C receives the bit shifted out, V = N XOR new C, and H is kept.
- R11: Code 18 exchanges bits 3..0 with bits 7..4, writes the result, and leaves all flags unchanged.
- R12: Whenever an operation updates N or V, S = N XOR V.
- R13: Unassigned codes 19 to 31 give `res_o`=0 and `wr_en_o`=0, and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Destination operand |
| b_i | input | 8 | Source operand or immediate |
| flags_i | input | 8 | Current status vector |
| res_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 8 | Next status vector |

## Verification
The unit holds no state, so any fault shows at the ports in the same cycle as the vector that exposes it. A wrong mask entry shows as a flag that changes when it should hold, or holds when it should change. The vectors set each incoming flag both ways, so that a preserved bit cannot match the expected value by chance. The carry-chaining Z rule, the overflow corners at 0x7F and 0x80 and the unassigned codes each need their own vector, because random operands rarely reach them.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  typedef logic [7:0] flags_t;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_SHL  = 5'd13, OP_SHR  = 5'd14, OP_ROL  = 5'd15,
    OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_SHIFT, CLS_NONE} op_cls_e;

  localparam flags_t M_ARITH = flags_t'((1 << F_C) | (1 << F_Z) | (1 << F_N) |
                                        (1 << F_V) | (1 << F_S) | (1 << F_H));
  localparam flags_t M_ZNVS  = flags_t'((1 << F_Z) | (1 << F_N) | (1 << F_V) | (1 << F_S));
  localparam flags_t M_CZNVS = flags_t'(M_ZNVS | (1 << F_C));

  function automatic flags_t op_mask(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: op_mask = M_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:                   op_mask = M_ZNVS;
      OP_COM, OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR:          op_mask = M_CZNVS;
      default:                                                 op_mask = '0;
    endcase
  endfunction

  function automatic op_cls_e op_class(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC,
      OP_NEG, OP_INC, OP_DEC:                         op_class = CLS_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_SWAP:         op_class = CLS_LOGIC;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR:         op_class = CLS_SHIFT;
      default:                                        op_class = CLS_NONE;
    endcase
  endfunction

  function automatic logic op_writes(alu_op_e op);
    op_writes = !(op == OP_CMP || op == OP_CMPC || op_class(op) == CLS_NONE);
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         z_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  localparam int HB = W / 2;

  logic [W-1:0] x, y;
  logic         cin, sub, chain;
  logic [W:0]   wide;
  logic [HB:0]  lo;
  logic         n, v;

  always_comb begin
    x = a_i; y = b_i; cin = 1'b0; sub = 1'b0; chain = 1'b0;
    case (op_i)
      OP_ADC:          cin = c_i;
      OP_SUB, OP_CMP:  sub = 1'b1;
      OP_SBC, OP_CMPC: begin sub = 1'b1; cin = c_i; chain = 1'b1; end
      OP_NEG:          begin x = '0; y = a_i; sub = 1'b1; end
      OP_INC:          y = W'(1);
      OP_DEC:          begin y = W'(1); sub = 1'b1; end
      default:         ;
    endcase
  end

  // borrow shows up as bit W / bit HB of the extended difference
  assign wide = sub ? ({1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin})
                    : ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin});
  assign lo   = sub ? ({1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin})
                    : ({1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin});
  assign res_o = wide[W-1:0];
  assign n     = res_o[W-1];
  assign v     = sub ? ((x[W-1] != y[W-1]) && (res_o[W-1] != x[W-1]))
                     : ((x[W-1] == y[W-1]) && (res_o[W-1] != x[W-1]));

  always_comb begin
    flags_o      = '0;
    flags_o[F_C] = wide[W];
    flags_o[F_Z] = (res_o == '0) && (!chain || z_i);
    flags_o[F_N] = n;
    flags_o[F_V] = v;
    flags_o[F_S] = n ^ v;
    flags_o[F_H] = lo[HB];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  localparam int HB = W / 2;

  logic [W-1:0] swapped;

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign swapped[i] = a_i[(i + HB) % W];
  end

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~a_i;
      OP_SWAP: res_o = swapped;
      default: res_o = '0;
    endcase
    flags_o      = '0;
    flags_o[F_C] = 1'b1;            // only consumed by complement
    flags_o[F_Z] = (res_o == '0);
    flags_o[F_N] = res_o[W-1];
    flags_o[F_S] = res_o[W-1];      // V is 0
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  logic co, n, v;

  always_comb begin
    co = a_i[0];
    case (op_i)
      OP_SHL:  begin res_o = {a_i[W-2:0], 1'b0};     co = a_i[W-1]; end
      OP_ROL:  begin res_o = {a_i[W-2:0], c_i};      co = a_i[W-1]; end
      OP_SHR:  res_o = {1'b0, a_i[W-1:1]};
      OP_ROR:  res_o = {c_i, a_i[W-1:1]};
      OP_ASR:  res_o = {a_i[W-1], a_i[W-1:1]};
      default: res_o = '0;
    endcase
    n = res_o[W-1];
    v = n ^ co;
    flags_o      = '0;
    flags_o[F_C] = co;
    flags_o[F_Z] = (res_o == '0);
    flags_o[F_N] = n;
    flags_o[F_V] = v;
    flags_o[F_S] = n ^ v;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic         wr_en_o,
  output logic [7:0]   flags_o
);
  alu_op_e      op;
  op_cls_e      cls;
  flags_t       mask, fresh;
  logic [W-1:0] ar_res, lg_res, sh_res;
  flags_t       ar_fl, lg_fl, sh_fl;

  assign op   = alu_op_e'(op_i);
  assign cls  = op_class(op);
  assign mask = op_mask(op);

  alu8_arith #(.W(W)) u_arith (
    .op_i(op), .a_i(a_i), .b_i(b_i), .c_i(flags_i[F_C]), .z_i(flags_i[F_Z]),
    .res_o(ar_res), .flags_o(ar_fl)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lg_res), .flags_o(lg_fl)
  );

  alu8_shift #(.W(W)) u_shift (
    .op_i(op), .a_i(a_i), .c_i(flags_i[F_C]), .res_o(sh_res), .flags_o(sh_fl)
  );

  always_comb begin
    case (cls)
      CLS_ARITH: begin res_o = ar_res; fresh = ar_fl; end
      CLS_LOGIC: begin res_o = lg_res; fresh = lg_fl; end
      CLS_SHIFT: begin res_o = sh_res; fresh = sh_fl; end
      default:   begin res_o = '0;     fresh = '0;    end
    endcase
  end

  assign wr_en_o = op_writes(op);
  assign flags_o = (fresh & mask) | (flags_i & ~mask);
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [4:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [7:0]   flags_i,
  input logic [W-1:0] res_o,
  input logic         wr_en_o,
  input logic [7:0]   flags_o
);
  always_comb begin
    if (!$isunknown({op_i, a_i, flags_i})) begin
      p_it_kept_r1: assert (flags_o[7:6] == flags_i[7:6])
        else $error("status bits 7:6 altered");
      if (op_i == 5'd4 || op_i == 5'd5) begin
        p_cmp_nowrite_r5: assert (!wr_en_o) else $error("compare wrote result");
      end
      if (op_i == 5'd3 || op_i == 5'd5) begin
        p_chain_z_r4: assert (flags_i[F_Z] || !flags_o[F_Z]) else $error("chained Z set");
      end
      if (op_i >= 5'd6 && op_i <= 5'd8) begin
        p_logic_keep_r6: assert (flags_o[F_C] == flags_i[F_C] && flags_o[F_H] == flags_i[F_H]
                                 && !flags_o[F_V]) else $error("logic op flag error");
      end
      if (op_i == 5'd11 || op_i == 5'd12) begin
        p_incdec_carry_r9: assert (flags_o[F_C] == flags_i[F_C] && flags_o[F_H] == flags_i[F_H])
          else $error("inc/dec touched C or H");
      end
      if (op_i == 5'd18) begin
        p_swap_flags_r11: assert (flags_o == flags_i && res_o == {a_i[W/2-1:0], a_i[W-1:W/2]})
          else $error("swap error");
      end
      if (op_i <= 5'd17) begin
        p_sign_r12: assert (flags_o[F_S] == (flags_o[F_N] ^ flags_o[F_V]))
          else $error("S != N^V");
      end
      if (op_i >= 5'd19) begin
        p_unused_r13: assert (!wr_en_o && flags_o == flags_i && res_o == '0)
          else $error("unassigned code had effect");
      end
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .op_i(op_i), .a_i(a_i), .flags_i(flags_i),
  .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic [4:0] op;
  logic [7:0] a, b, fin;
  logic [7:0] res;
  logic       we;
  logic [7:0] fout;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u_dut (
    .op_i(op), .a_i(a), .b_i(b), .flags_i(fin),
    .res_o(res), .wr_en_o(we), .flags_o(fout)
  );

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic string req_of(input int o);
    case (o)
      0, 1:      return "R2";
      2:         return "R3";
      3:         return "R4";
      4, 5:      return "R5";
      6, 7, 8:   return "R6";
      9:         return "R7";
      10:        return "R8";
      11, 12:    return "R9";
      13, 14, 15, 16, 17: return "R10";
      18:        return "R11";
      default:   return "R13";
    endcase
  endfunction

  // behavioural model; each vector also checks R1 (bits 7:6) and R12 (S)
  task automatic model(input int o, input int x, input int y, input logic [7:0] f,
                       output int r, output logic w, output logic [7:0] fo);
    int s, sv, cin;
    logic c, z, n, v, h;
    logic uc, uz, un, uv, uh;
    fo = f; w = 1; r = 0;
    c = 0; z = 0; n = 0; v = 0; h = 0;
    uc = 0; uz = 0; un = 0; uv = 0; uh = 0;
    if (o <= 5 || o == 10) begin
      cin = (o == 1 || o == 3 || o == 5) ? int'(f[0]) : 0;
      if (o == 10) begin y = x; x = 0; end
      if (o <= 1) begin
        s = x + y + cin; c = s > 255;
        h = ((x & 15) + (y & 15) + cin) > 15; sv = sx(x) + sx(y) + cin;
      end else begin
        s = x - y - cin; c = s < 0;
        h = ((x & 15) - (y & 15) - cin) < 0; sv = sx(x) - sx(y) - cin;
      end
      r = s & 255; v = (sv > 127) || (sv < -128);
      z = (r == 0); if (o == 3 || o == 5) z = z && f[1];
      uc = 1; uz = 1; un = 1; uv = 1; uh = 1;
      if (o == 4 || o == 5) w = 0;
    end else if (o <= 8) begin
      r = (o == 6) ? (x & y) : (o == 7) ? (x | y) : (x ^ y);
      uz = 1; un = 1; uv = 1; z = (r == 0);
    end else if (o == 9) begin
      r = 255 - x; c = 1; uc = 1; uz = 1; un = 1; uv = 1; z = (r == 0);
    end else if (o == 11 || o == 12) begin
      r = (o == 11) ? ((x + 1) & 255) : ((x + 255) & 255);
      v = (o == 11) ? (x == 127) : (x == 128);
      uz = 1; un = 1; uv = 1; z = (r == 0);
    end else if (o <= 17) begin
      case (o)
        13: begin r = (x * 2) & 255;           c = x >= 128; end
        14: begin r = x / 2;                   c = x % 2; end
        15: begin r = ((x * 2) & 255) + f[0];  c = x >= 128; end
        16: begin r = x / 2 + 128 * f[0];      c = x % 2; end
        default: begin r = x / 2 + (x & 128);  c = x % 2; end
      endcase
      z = (r == 0); n = r >= 128; v = n ^ c;
      uc = 1; uz = 1; un = 1; uv = 1;
    end else if (o == 18) begin
      r = ((x % 16) * 16) + (x / 16);
    end else begin
      w = 0; r = 0;
    end
    n = r >= 128;
    if (uc) fo[0] = c;
    if (uz) fo[1] = z;
    if (un) fo[2] = n;
    if (uv) fo[3] = v;
    if (un || uv) fo[4] = n ^ v;
    if (uh) fo[5] = h;
  endtask

  task automatic apply(input int o, input int x, input int y, input logic [7:0] f);
    int er; logic ew; logic [7:0] ef;
    @(posedge clk);
    op = 5'(o); a = 8'(x); b = 8'(y); fin = f;
    model(o, x, y, f, er, ew, ef);
    @(negedge clk);
    vectors++;
    if (res !== 8'(er) || we !== ew || fout !== ef) begin
      errors++;
      $display("FAIL %s (R1/R12 layout) op=%0d a=%02h b=%02h f=%02h: actual res=%02h we=%0b fl=%02h expected res=%02h we=%0b fl=%02h",
               req_of(o), o, x, y, f, res, we, fout, er[7:0], ew, ef);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    op = '0; a = '0; b = '0; fin = '0;
    apply(0, 0, 0, 8'h00);                 // idle: zero operands, R2
    apply(0, 8'h7F, 8'h01, 8'hC0);         // R2 overflow + half carry, R1 keep I/T
    apply(1, 8'hFF, 8'h00, 8'h01);         // R2 carry chain to zero
    apply(2, 8'h00, 8'h01, 8'h00);         // R3 borrow
    apply(2, 8'h80, 8'h01, 8'h00);         // R3 signed overflow
    apply(3, 8'h05, 8'h05, 8'h00);         // R4 zero result but Z in = 0
    apply(3, 8'h05, 8'h05, 8'h02);         // R4 zero result, Z in = 1
    apply(5, 8'h10, 8'h0F, 8'h03);         // R5 compare with carry, no write
    apply(4, 8'h33, 8'h33, 8'h00);         // R5 compare equal
    apply(6, 8'hF0, 8'h0F, 8'h29);         // R6 AND -> 0, keeps C and H
    apply(8, 8'hAA, 8'h55, 8'h08);         // R6 XOR clears V
    apply(9, 8'hFF, 0, 8'h20);             // R7 complement, keeps H
    apply(10, 8'h80, 0, 8'h00);            // R8 negate overflow
    apply(10, 8'h00, 0, 8'h3F);            // R8 negate zero
    apply(11, 8'h7F, 0, 8'h21);            // R9 inc overflow keeps C, H
    apply(12, 8'h80, 0, 8'h00);            // R9 dec overflow
    apply(12, 8'h00, 0, 8'h01);            // R9 dec wrap keeps C
    apply(15, 8'h80, 0, 8'h01);            // R10 rotate left through carry
    apply(16, 8'h01, 0, 8'h00);            // R10 rotate right to zero
    apply(17, 8'h81, 0, 8'h20);            // R10 arithmetic shift keeps bit 7
    apply(14, 8'h01, 0, 8'h00);            // R10 shift right to zero
    apply(18, 8'h3C, 0, 8'hFF);            // R11 swap, no flags
    apply(19, 8'h12, 8'h34, 8'h55);        // R13 unassigned
    apply(31, 8'hFF, 8'hFF, 8'hAA);        // R13 unassigned
    for (int i = 0; i < 4000; i++)
      apply(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule